// File: doc/BRIEF.md
# Wide Synchronous Link Flit Framer

This block holds both ends of a short, wide, single-clock link between two switches. Each clock carries one 24-bit phit. Twenty bits run forward: 16 bits of payload and 4 control bits, 2 of which hold a flit type code. Four bits run in the reverse direction and carry flow control. A flit is the same size as a phit, so one payload word moves per clock.

The transmit side takes packet words from a valid/ready stream. The first word of a packet is its routing tag and the last word is marked. The transmit side registers each accepted word onto the link with its type code and sends idle flits whenever the far end signals stop. The receive side latches the forward bits on the shared clock with no synchronizer. It checks the framing order of the flits, stores accepted flits in a small buffer, presents them on an output stream with packet boundaries restored, and drives stop back while the buffer is nearly full.

In a system, `tx_phit_o`/`tx_rev_i` connect to a neighbour's receive side and `rx_phit_i`/`rx_rev_o` connect to a neighbour's transmit side. The two halves can also be looped back to each other.

Top module: `link_framer`

## Requirements
- R1: Forward phit layout is bits [15:0] payload, bits [17:16] type code (2'b00 idle, 2'b01 routing tag, 2'b10 packet body, 2'b11 end of packet) and bits [19:18] reserved, driven 0. Reverse bit 0 is stop and reverse bits [3:1] are reserved, driven 0.
- R2: A word accepted at a clock edge (`in_valid && in_ready`) appears on `tx_phit_o` after that edge. It is typed tag if `in_tag` is set, else end if `in_last` is set, else body. When no word is accepted, the next phit is idle.
- R3: `in_ready` equals the inverse of `tx_rev_i[0]`. While stop is seen, the transmitter sends only idle flits.
- R4: `rx_rev_o[0]` goes high one cycle after the receive buffer holds DEPTH-2 or more entries (6 of 8 by default). It goes low one cycle after the buffer falls below that level.
- R5: With the two halves looped back and the consumer stalling at random, no flit is lost or duplicated and the receive buffer never overflows.
- R6: Accepted flits leave on the output stream in arrival order. `out_tag` marks a routing tag, `out_last` marks an end-of-packet flit, and `out_data` carries the payload.
- R7: A body or end flit that arrives outside a packet is discarded, and `framing_err` pulses high for one cycle after the clock edge that latched it.
- R8: A routing tag that arrives inside a packet is discarded and pulses `framing_err`. The open packet stays open, and its later body and end flits are delivered.
- R9: Idle flits are discarded whatever their payload bits hold. The reserved forward bits have no effect on decoding.
- R10: During reset, `tx_phit_o` is all zero, `rx_rev_o` is zero, `out_valid` is low and `framing_err` is low.
- R11: A packet with one payload word is a tag flit followed by a single end flit that carries the word, and it is delivered as exactly those two flits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared link clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Transmit word valid |
| in_ready | output | 1 | Transmit word accepted at this edge when valid |
| in_tag | input | 1 | Word is the routing tag of a new packet |
| in_last | input | 1 | Word is the last payload word of the packet |
| in_data | input | 16 | Transmit word |
| tx_phit_o | output | 20 | Forward link bits toward the far receiver |
| tx_rev_i | input | 4 | Reverse flow-control bits from the far receiver |
| rx_phit_i | input | 20 | Forward link bits from the far transmitter |
| rx_rev_o | output | 4 | Reverse flow-control bits toward the far transmitter |
| out_valid | output | 1 | Received flit available |
| out_ready | input | 1 | Consumer takes the flit at this edge |
| out_tag | output | 1 | Received flit is a routing tag |
| out_last | output | 1 | Received flit ends its packet |
| out_data | output | 16 | Received payload word |
| framing_err | output | 1 | One-cycle pulse on a framing violation |

## Verification
A wrong in-packet state in the receiver shows up one cycle after the next non-idle flit. A legal flit then raises `framing_err` without cause, or a flit that should have been dropped appears on `out_valid`. A buffer count that is off shows up as stop rising or falling one or more cycles early or late, measured against the number of flits held. Under random stalls, stop that is late lets flits arrive at a full buffer and be lost. Stop that is dropped too soon causes the same loss. A type-code or stream-order fault shows up on the output stream as soon as the affected flit is popped and compared with the expected packet sequence.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic [1:0] {
    FT_IDLE = 2'b00,
    FT_TAG  = 2'b01,
    FT_BODY = 2'b10,
    FT_END  = 2'b11
  } flit_t;

  localparam int CTL_W = 4;
  localparam int REV_W = 4;
endpackage

// File: rtl/lf_tx.sv
module lf_tx
  import lf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_tag,
  input  logic                in_last,
  input  logic [DW-1:0]       in_data,
  input  logic [REV_W-1:0]    rev_i,
  output logic [DW+CTL_W-1:0] phit_o
);
  flit_t         kind_q, kind_nxt;
  logic [DW-1:0] data_q;
  logic          accept;
  logic          unused_rev;

  assign unused_rev = ^rev_i[REV_W-1:1];

  always_comb begin
    in_ready = ~rev_i[0];
    accept   = in_valid & ~rev_i[0];
    if (!accept)      kind_nxt = FT_IDLE;
    else if (in_tag)  kind_nxt = FT_TAG;
    else if (in_last) kind_nxt = FT_END;
    else              kind_nxt = FT_BODY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= FT_IDLE;
      data_q <= '0;
    end else begin
      kind_q <= kind_nxt;
      if (accept) data_q <= in_data;
    end
  end

  assign phit_o = {2'b00, kind_q, data_q};

  // R2
  accept_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (kind_q != FT_IDLE));

  // R3
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rev_i[0] |=> (kind_q == FT_IDLE));
endmodule

// File: rtl/lf_rx_frame.sv
module lf_rx_frame
  import lf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DW+CTL_W-1:0] phit_i,
  output logic                wr_en,
  output logic [DW+1:0]       wr_word,
  output logic                err_o
);
  flit_t kind;
  logic  in_pkt, pkt_nxt;
  logic  bad;
  logic  unused_rsvd;

  assign unused_rsvd = ^phit_i[DW+CTL_W-1:DW+2];

  always_comb begin
    kind    = flit_t'(phit_i[DW+1:DW]);
    wr_en   = 1'b0;
    bad     = 1'b0;
    pkt_nxt = in_pkt;
    unique case (kind)
      FT_IDLE: ;
      FT_TAG: begin
        if (in_pkt) bad = 1'b1;
        else begin
          wr_en   = 1'b1;
          pkt_nxt = 1'b1;
        end
      end
      FT_BODY: begin
        if (!in_pkt) bad = 1'b1;
        else wr_en = 1'b1;
      end
      FT_END: begin
        if (!in_pkt) bad = 1'b1;
        else begin
          wr_en   = 1'b1;
          pkt_nxt = 1'b0;
        end
      end
      default: ;
    endcase
  end

  assign wr_word = {kind, phit_i[DW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      in_pkt <= pkt_nxt;
      err_o  <= bad;
    end
  end

  // R7
  orphan_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_pkt && (kind == FT_BODY || kind == FT_END)) |=> err_o);

  // R8
  nested_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && kind == FT_TAG) |=> (err_o && in_pkt));
endmodule

// File: rtl/lf_fifo.sv
module lf_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_nxt, rptr_nxt;
  logic [CW-1:0] count_nxt;

  always_comb begin
    wptr_nxt  = wptr;
    rptr_nxt  = rptr;
    count_nxt = count;
    if (push) wptr_nxt = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
    if (pop)  rptr_nxt = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    if (push && !pop)      count_nxt = count + 1'b1;
    else if (pop && !push) count_nxt = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr_nxt;
      rptr  <= rptr_nxt;
      count <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  assign dout  = mem[rptr];
  assign empty = (count == '0);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH)));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/lf_flow.sv
module lf_flow
  import lf_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int LOOP_FLIT = 2,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    count,
  output logic [REV_W-1:0] rev_o
);
  logic [CW-1:0] free;
  logic          stop_q, stop_nxt;

  always_comb begin
    free     = CW'(DEPTH) - count;
    stop_nxt = (free <= CW'(LOOP_FLIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= 1'b0;
    else        stop_q <= stop_nxt;
  end

  assign rev_o = {{(REV_W-1){1'b0}}, stop_q};
endmodule

// File: rtl/link_framer.sv
module link_framer
  import lf_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BUF_DEPTH = 8,
  localparam int PHIT_W   = DATA_W + CTL_W,
  localparam int ENT_W    = DATA_W + 2,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1),
  localparam int LOOP_F   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_tag,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  output logic [PHIT_W-1:0] tx_phit_o,
  input  logic [REV_W-1:0]  tx_rev_i,
  input  logic [PHIT_W-1:0] rx_phit_i,
  output logic [REV_W-1:0]  rx_rev_o,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_tag,
  output logic              out_last,
  output logic [DATA_W-1:0] out_data,
  output logic              framing_err
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             wr_en, pop, empty;
  logic [ENT_W-1:0] wr_word, rd_word;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  lf_tx #(.DW(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_int_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_last(in_last), .in_data(in_data),
    .rev_i(tx_rev_i), .phit_o(tx_phit_o)
  );

  lf_rx_frame #(.DW(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_int_n), .phit_i(rx_phit_i),
    .wr_en(wr_en), .wr_word(wr_word), .err_o(framing_err)
  );

  lf_fifo #(.W(ENT_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_int_n),
    .push(wr_en), .din(wr_word), .pop(pop),
    .dout(rd_word), .empty(empty), .count(count)
  );

  lf_flow #(.DEPTH(BUF_DEPTH), .LOOP_FLIT(LOOP_F)) u_flow (
    .clk(clk), .rst_n(rst_int_n), .count(count), .rev_o(rx_rev_o)
  );

  always_comb begin
    out_valid = ~empty;
    pop       = out_valid & out_ready;
    out_tag   = (rd_word[ENT_W-1:DATA_W] == FT_TAG);
    out_last  = (rd_word[ENT_W-1:DATA_W] == FT_END);
    out_data  = rd_word[DATA_W-1:0];
  end

  // R1
  rsvd_fwd_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    tx_phit_o[PHIT_W-1:DATA_W+2] == '0);

  // R7
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    framing_err |-> $stable(count) || out_ready);

  initial begin
    if (BUF_DEPTH < LOOP_F + 2) $error("buffer too shallow for stop loop");
  end
endmodule

// File: tb/link_framer_test.sv
module link_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int PW = DW + 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_tag, in_last, out_ready;
  logic          in_ready, out_valid, out_tag, out_last, framing_err;
  logic [DW-1:0] in_data, out_data;
  logic [PW-1:0] tx_phit_o, rx_phit_i, inj_phit;
  logic [3:0]    tx_rev_i, rx_rev_o;
  logic          inj_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [17:0] prodq[$];
  logic [17:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rx_phit_i = inj_en ? inj_phit : tx_phit_o;
  assign tx_rev_i  = rx_rev_o;

  link_framer uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
    .in_last(in_last), .in_data(in_data),
    .tx_phit_o(tx_phit_o), .tx_rev_i(tx_rev_i),
    .rx_phit_i(rx_phit_i), .rx_rev_o(rx_rev_o),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
    .out_last(out_last), .out_data(out_data), .framing_err(framing_err)
  );

  function automatic logic [PW-1:0] mk(logic [1:0] k, logic [15:0] d, logic [1:0] rsv);
    return {rsv, k, d};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(string req, logic [1:0] k, logic [15:0] d);
    chk(out_valid == 1'b1, req, "out_valid", 32'(out_valid), 32'd1);
    chk(out_data == d, req, "out_data", 32'(out_data), 32'(d));
    chk(out_tag == (k == 2'b01) && out_last == (k == 2'b11), req, "out flags",
        {30'd0, out_tag, out_last}, {30'd0, k == 2'b01, k == 2'b11});
  endtask

  task automatic inj_chk(logic [PW-1:0] p, bit e_err, bit e_v, logic [1:0] k,
                         logic [15:0] d, string req);
    inj_phit = p;
    @(negedge clk);
    chk(framing_err == e_err, req, "framing_err", 32'(framing_err), 32'(e_err));
    if (e_v) chk_out(req, k, d);
    else chk(out_valid == 1'b0, req, "out_valid", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int npkt, popped, total;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; in_valid = 1'b0; in_tag = 1'b0; in_last = 1'b0;
    in_data = '0; out_ready = 1'b1; inj_en = 1'b0; inj_phit = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(tx_phit_o == '0, "R10", "tx_phit_o", 32'(tx_phit_o), 32'd0);
    chk(rx_rev_o == '0, "R10", "rx_rev_o", 32'(rx_rev_o), 32'd0);
    chk(out_valid == 1'b0, "R10", "out_valid", 32'(out_valid), 32'd0);
    chk(framing_err == 1'b0, "R10", "framing_err", 32'(framing_err), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R11 R6 R1: single-word packet through the loop
    in_valid = 1'b1; in_tag = 1'b1; in_data = 16'hA5A5;
    chk(in_ready == 1'b1, "R3", "in_ready no stop", 32'(in_ready), 32'd1);
    @(negedge clk);
    chk(tx_phit_o == mk(2'b01, 16'hA5A5, 2'b00), "R1", "tag phit", 32'(tx_phit_o),
        32'(mk(2'b01, 16'hA5A5, 2'b00)));
    in_tag = 1'b0; in_last = 1'b1; in_data = 16'h5A5A;
    @(negedge clk);
    chk(tx_phit_o == mk(2'b11, 16'h5A5A, 2'b00), "R11", "end phit", 32'(tx_phit_o),
        32'(mk(2'b11, 16'h5A5A, 2'b00)));
    chk_out("R6", 2'b01, 16'hA5A5);
    in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    chk(tx_phit_o[17:16] == 2'b00, "R2", "idle when no word", 32'(tx_phit_o[17:16]), 32'd0);
    chk_out("R11", 2'b11, 16'h5A5A);
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", "only two flits", 32'(out_valid), 32'd0);

    // R4 stop threshold and R3 transmitter hold-off
    out_ready = 1'b0; inj_en = 1'b1;
    inj_phit = mk(2'b01, 16'h1000, 2'b00);
    @(negedge clk);
    for (int i = 1; i <= 4; i++) begin
      inj_phit = mk(2'b10, 16'(16'h1000 + i), 2'b00);
      @(negedge clk);
    end
    inj_phit = '0;
    repeat (2) @(negedge clk);
    chk(rx_rev_o == 4'b0000, "R4", "no stop at 5 held", 32'(rx_rev_o), 32'd0);
    inj_phit = mk(2'b10, 16'h1005, 2'b00);
    @(negedge clk);
    inj_phit = '0;
    chk(rx_rev_o == 4'b0000, "R4", "stop not yet", 32'(rx_rev_o), 32'd0);
    @(negedge clk);
    chk(rx_rev_o == 4'b0001, "R4", "stop at 6 held", 32'(rx_rev_o), 32'd1);
    chk(in_ready == 1'b0, "R3", "in_ready under stop", 32'(in_ready), 32'd0);
    in_valid = 1'b1; in_tag = 1'b1; in_data = 16'h7777;
    @(negedge clk);
    chk(tx_phit_o[17:16] == 2'b00, "R3", "idle under stop", 32'(tx_phit_o[17:16]), 32'd0);
    in_valid = 1'b0; in_tag = 1'b0;
    inj_phit = mk(2'b11, 16'h0E0E, 2'b00);
    @(negedge clk);
    inj_phit = '0;
    for (int i = 0; i < 7; i++) begin
      chk_out("R6", (i == 0) ? 2'b01 : (i == 6) ? 2'b11 : 2'b10,
              (i == 6) ? 16'h0E0E : 16'(16'h1000 + i));
      out_ready = 1'b1;
      @(negedge clk);
    end
    chk(out_valid == 1'b0, "R6", "drained", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk(rx_rev_o == 4'b0000, "R4", "stop released", 32'(rx_rev_o), 32'd0);

    // R5 R6: random packets through loopback with random stalls
    inj_en = 1'b0;
    npkt = 40;
    for (int p = 0; p < npkt; p++) begin
      int nb;
      logic [15:0] d;
      nb = $urandom % 6;
      d = 16'($urandom);
      prodq.push_back({1'b1, 1'b0, d}); expq.push_back({2'b01, d});
      for (int b = 0; b < nb; b++) begin
        d = 16'($urandom);
        prodq.push_back({1'b0, 1'b0, d}); expq.push_back({2'b10, d});
      end
      d = 16'($urandom);
      prodq.push_back({1'b0, 1'b1, d}); expq.push_back({2'b11, d});
    end
    total = expq.size();
    popped = 0;
    fork
      begin
        int idx = 0;
        while (idx < prodq.size()) begin
          @(negedge clk);
          if ($urandom % 10 < 7) begin
            in_valid = 1'b1;
            {in_tag, in_last, in_data} = prodq[idx];
            if (in_ready) idx++;
          end else begin
            in_valid = 1'b0;
          end
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin
        while (popped < total) begin
          bit r;
          @(negedge clk);
          r = 1'($urandom % 2);
          if (r && out_valid) begin
            chk_out("R5", expq[popped][17:16], expq[popped][15:0]);
            popped++;
          end
          out_ready = r;
        end
      end
    join
    @(negedge clk);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R5", "no extra flits", 32'(out_valid), 32'd0);
    chk(popped == total, "R5", "flit count", 32'(popped), 32'(total));

    // R7 R8 R9: injected framing faults
    inj_en = 1'b1;
    inj_chk(mk(2'b10, 16'hDEAD, 2'b00), 1'b1, 1'b0, 2'b00, 16'h0, "R7");
    inj_chk(mk(2'b00, 16'hBEEF, 2'b00), 1'b0, 1'b0, 2'b00, 16'h0, "R9");
    inj_chk(mk(2'b11, 16'hCAFE, 2'b00), 1'b1, 1'b0, 2'b00, 16'h0, "R7");
    inj_chk(mk(2'b01, 16'h1111, 2'b11), 1'b0, 1'b1, 2'b01, 16'h1111, "R9");
    inj_chk(mk(2'b01, 16'h2222, 2'b00), 1'b1, 1'b0, 2'b00, 16'h0, "R8");
    inj_chk(mk(2'b00, 16'hFFFF, 2'b11), 1'b0, 1'b0, 2'b00, 16'h0, "R9");
    inj_chk(mk(2'b11, 16'h3333, 2'b00), 1'b0, 1'b1, 2'b11, 16'h3333, "R8");
    inj_chk(mk(2'b00, 16'h0000, 2'b00), 1'b0, 1'b0, 2'b00, 16'h0, "R9");
    inj_en = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule